// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits beside a NOR-style flash array model. It produces the status byte that the data bus returns while an internal program or erase operation is in flight. It records which sectors an erase has selected, and whether that erase is running or parked in suspend. It also counts internal pulses against a limit and raises a failure flag when the limit is reached.

Host software tells the block apart from array data by reading the byte twice and comparing toggle bits. Two toggle bits carry complementary information:

- Bit 6 flips on every read while an operation is running, whatever the address.
- Bit 2 flips only when the read address falls in a sector selected for erase, and it flips the same way whether that erase is running or suspended.

The command decoder feeds the block one-cycle command pulses. Each pulse marks the closing write strobe of a command sequence. The array engine feeds pulse ticks, a completion pulse and an overwrite-fault pulse.

Top module: `flash_op_status`

## Requirements
- R1: After reset `statusMode` is 0 and `statusByte` is 8'h00.
- R2: A program or erase start is accepted only when no operation is in progress, and it is ignored otherwise. `statusMode` goes to 1 on the clock after an accepted start. If both starts arrive together, program wins.
- R3: While a program or an active erase runs, bit 6 inverts on every read cycle, whether the read comes from `oeRead` or `ceRead` (a read is `oeRead | ceRead`).
- R4: Bit 6 keeps its value while an erase is suspended and while no operation runs.
- R5: During an erase, running or suspended, bit 2 inverts on a read whose `secAddr` selects a bit set in the erase mask captured at start. Reads of unselected sectors, reads during a program and reads while idle leave bit 2 unchanged.
- R6: `suspendCmd` moves only an active erase to suspended, and `resumeCmd` moves it back. Pulse ticks are not counted while suspended, and `opDone` is ignored while suspended.
- R7: Pulse ticks during an active operation increment a counter that clears at start. The tick that brings it to `PULSE_LIMIT` sets bit 5.
- R8: `progFault` during an active program sets bit 5.
- R9: Once bit 5 is set it stays set until `resetCmd`. While bit 5 is set, `opDone` is ignored and the operation stays busy, so bit 6 keeps toggling.
- R10: `opDone` during an active operation with bit 5 clear returns `statusMode` to 0. Bits 6 and 2 then hold their values.
- R11: `resetCmd` overrides every other input in the same cycle. On the next clock `statusMode` is 0 and `statusByte` is 8'h00.
- R12: Bits 7, 4, 3, 1 and 0 of `statusByte` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oeRead | input | 1 | Read cycle via output-enable, one pulse per read |
| ceRead | input | 1 | Read cycle via chip-enable, one pulse per read |
| secAddr | input | SEC_W | Sector index of the read address |
| startProg | input | 1 | Program command completed |
| startErase | input | 1 | Erase command completed |
| eraseMask | input | NUM_SEC | Sectors selected by the erase command |
| suspendCmd | input | 1 | Erase suspend command |
| resumeCmd | input | 1 | Erase resume command |
| resetCmd | input | 1 | Reset command, returns to array-read mode |
| opDone | input | 1 | Array engine reports operation finished |
| pulseTick | input | 1 | One internal program or erase pulse issued |
| progFault | input | 1 | Program tried to raise a 0 bit to 1 |
| statusByte | output | 8 | Status byte: bit 6 run toggle, bit 5 limit flag, bit 2 sector toggle |
| statusMode | output | 1 | 1 while status, not array data, is presented |

## Verification
The assertions assume that every command and read input is a single-cycle pulse sampled on the rising clock, and that `secAddr` is below `NUM_SEC` whenever a read is strobed. They also assume reset is released only between edges. The bench changes inputs only on the falling edge and holds each pulse for one cycle. It keeps addresses inside the sector range and mostly issues one command per cycle. The exceptions are deliberate collisions (both starts together, reset beside a start) that probe the priority rules.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_SUSP  = 2'd3
  } opState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic opActive;  // program or erase running (not suspended)
    logic eraseSel;  // erase running or suspended
    logic loadMask;  // capture erase sector mask
    logic clrAll;    // reset command: clear toggles and mask
  } ctrlStrb_t;

endpackage

// File: rtl/flash_stat_ctrl.sv
module flash_stat_ctrl
  import flash_stat_pkg::*;
#(
  parameter int PULSE_LIMIT = 6,
  parameter int CNT_W       = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startProg,
  input  logic      startErase,
  input  logic      suspendCmd,
  input  logic      resumeCmd,
  input  logic      resetCmd,
  input  logic      opDone,
  input  logic      pulseTick,
  input  logic      progFault,
  output ctrlStrb_t strb,
  output logic      timedOut,
  output logic      statusMode
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(PULSE_LIMIT);

  opState_t         state, stateNxt;
  logic [CNT_W-1:0] pulseCnt, cntNxt;
  logic             toNxt;
  logic             inSusp;

  always_comb begin
    stateNxt = state;
    cntNxt   = pulseCnt;
    toNxt    = timedOut;
    if (resetCmd) begin
      stateNxt = OP_IDLE;
      cntNxt   = '0;
      toNxt    = 1'b0;
    end else begin
      unique case (state)
        OP_IDLE: begin
          if (startProg) begin
            stateNxt = OP_PROG;
            cntNxt   = '0;
            toNxt    = 1'b0;
          end else if (startErase) begin
            stateNxt = OP_ERASE;
            cntNxt   = '0;
            toNxt    = 1'b0;
          end
        end
        OP_PROG, OP_ERASE: begin
          if (opDone && !timedOut) begin
            stateNxt = OP_IDLE;
          end else begin
            if (state == OP_ERASE && suspendCmd) stateNxt = OP_SUSP;
            if (pulseTick && pulseCnt != LIM) begin
              cntNxt = pulseCnt + 1'b1;
              if (pulseCnt == LIM - 1'b1) toNxt = 1'b1;
            end
            if (state == OP_PROG && progFault) toNxt = 1'b1;
          end
        end
        OP_SUSP: begin
          if (resumeCmd) stateNxt = OP_ERASE;
        end
        default: stateNxt = OP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= OP_IDLE;
      pulseCnt <= '0;
      timedOut <= 1'b0;
    end else begin
      state    <= stateNxt;
      pulseCnt <= cntNxt;
      timedOut <= toNxt;
    end
  end

  always_comb begin
    strb.opActive = (state == OP_PROG) || (state == OP_ERASE);
    strb.eraseSel = (state == OP_ERASE) || (state == OP_SUSP);
    strb.loadMask = (state == OP_IDLE) && startErase && !startProg && !resetCmd;
    strb.clrAll   = resetCmd;
  end

  assign statusMode = (state != OP_IDLE);
  assign inSusp     = (state == OP_SUSP);

  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetCmd |=> (state == OP_IDLE && !timedOut));

  // R9
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timedOut && !resetCmd) |=> timedOut);

  // R6
  susp_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inSusp) |-> ($past(state) == OP_ERASE));

  // R6
  susp_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inSusp && !resetCmd) |=> $stable(pulseCnt));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= LIM);

endmodule

// File: rtl/flash_stat_dpath.sv
module flash_stat_dpath
  import flash_stat_pkg::*;
#(
  parameter int NUM_SEC = 8,
  parameter int SEC_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic               readStb,
  input  logic [SEC_W-1:0]   secAddr,
  input  logic [NUM_SEC-1:0] eraseMask,
  input  logic               timedOut,
  output logic [7:0]         statusByte
);

  logic [NUM_SEC-1:0] maskReg;
  logic [NUM_SEC-1:0] secHit;
  logic               addrHit;
  logic               tog6, tog2;

  for (genvar i = 0; i < NUM_SEC; i++) begin : g_hit
    assign secHit[i] = maskReg[i] && (secAddr == SEC_W'(i));
  end
  assign addrHit = |secHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      tog6    <= 1'b0;
      tog2    <= 1'b0;
    end else if (strb.clrAll) begin
      maskReg <= '0;
      tog6    <= 1'b0;
      tog2    <= 1'b0;
    end else begin
      if (strb.loadMask)                       maskReg <= eraseMask;
      if (readStb && strb.opActive)            tog6    <= ~tog6;
      if (readStb && strb.eraseSel && addrHit) tog2    <= ~tog2;
    end
  end

  always_comb begin
    statusByte    = 8'h00;
    statusByte[6] = tog6;
    statusByte[5] = timedOut;
    statusByte[2] = tog2;
  end

  // R3
  tog6_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readStb && strb.opActive && !strb.clrAll) |=> (tog6 != $past(tog6)));

  // R4
  tog6_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.opActive && !strb.clrAll) |=> $stable(tog6));

  // R5
  tog2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((!strb.eraseSel || !readStb) && !strb.clrAll) |=> $stable(tog2));

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import flash_stat_pkg::*;
#(
  parameter int NUM_SEC     = 8,
  parameter int PULSE_LIMIT = 6,
  parameter int SEC_W       = (NUM_SEC > 1) ? $clog2(NUM_SEC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               oeRead,
  input  logic               ceRead,
  input  logic [SEC_W-1:0]   secAddr,
  input  logic               startProg,
  input  logic               startErase,
  input  logic [NUM_SEC-1:0] eraseMask,
  input  logic               suspendCmd,
  input  logic               resumeCmd,
  input  logic               resetCmd,
  input  logic               opDone,
  input  logic               pulseTick,
  input  logic               progFault,
  output logic [7:0]         statusByte,
  output logic               statusMode
);

  localparam int CNT_W = $clog2(PULSE_LIMIT + 1);

  ctrlStrb_t strb;
  logic      timedOut;
  logic      readStb;

  assign readStb = oeRead | ceRead;

  flash_stat_ctrl #(
    .PULSE_LIMIT(PULSE_LIMIT),
    .CNT_W      (CNT_W)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startProg (startProg),
    .startErase(startErase),
    .suspendCmd(suspendCmd),
    .resumeCmd (resumeCmd),
    .resetCmd  (resetCmd),
    .opDone    (opDone),
    .pulseTick (pulseTick),
    .progFault (progFault),
    .strb      (strb),
    .timedOut  (timedOut),
    .statusMode(statusMode)
  );

  flash_stat_dpath #(
    .NUM_SEC(NUM_SEC),
    .SEC_W  (SEC_W)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .readStb   (readStb),
    .secAddr   (secAddr),
    .eraseMask (eraseMask),
    .timedOut  (timedOut),
    .statusByte(statusByte)
  );

  // R12
  zero_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte & 8'b1001_1011) == 8'h00);

endmodule

// File: tb/test_flash_op_status.sv
module test_flash_op_status;

  localparam int NSEC = 8;
  localparam int LIM  = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oeRead = 0, ceRead = 0;
  logic [2:0] secAddr = '0;
  logic       startProg = 0, startErase = 0;
  logic [7:0] eraseMask = '0;
  logic       suspendCmd = 0, resumeCmd = 0, resetCmd = 0;
  logic       opDone = 0, pulseTick = 0, progFault = 0;
  logic [7:0] statusByte;
  logic       statusMode;

  always #2 clk = ~clk;

  flash_op_status #(.NUM_SEC(NSEC), .PULSE_LIMIT(LIM)) i_flash_op_status (
    .clk(clk), .rstN(rstN), .oeRead(oeRead), .ceRead(ceRead),
    .secAddr(secAddr), .startProg(startProg), .startErase(startErase),
    .eraseMask(eraseMask), .suspendCmd(suspendCmd), .resumeCmd(resumeCmd),
    .resetCmd(resetCmd), .opDone(opDone), .pulseTick(pulseTick),
    .progFault(progFault), .statusByte(statusByte), .statusMode(statusMode)
  );

  // Reference model: 0 idle, 1 program, 2 erase, 3 suspended
  int         mSt = 0, mCnt = 0;
  bit         mTo = 0, mT6 = 0, mT2 = 0;
  bit [7:0]   mMask = '0;
  int         nChecks = 0, nFails = 0;
  int         cycles = 0;
  bit         finished = 0;

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got mode/byte %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    bit rd = oeRead | ceRead;
    if (resetCmd) begin
      mSt = 0; mCnt = 0; mTo = 0; mT6 = 0; mT2 = 0; mMask = '0;
      return;
    end
    if (rd && (mSt == 1 || mSt == 2)) mT6 = !mT6;
    if (rd && (mSt == 2 || mSt == 3) && mMask[secAddr]) mT2 = !mT2;
    case (mSt)
      0: begin
        if (startProg) begin mSt = 1; mCnt = 0; mTo = 0; end
        else if (startErase) begin mSt = 2; mCnt = 0; mTo = 0; mMask = eraseMask; end
      end
      1, 2: begin
        if (opDone && !mTo) mSt = 0;
        else begin
          bit wasProg = (mSt == 1);
          if (mSt == 2 && suspendCmd) mSt = 3;
          if (pulseTick && mCnt < LIM) begin
            mCnt++;
            if (mCnt == LIM) mTo = 1;
          end
          if (wasProg && progFault) mTo = 1;
        end
      end
      default: if (resumeCmd) mSt = 2;
    endcase
  endtask

  function automatic logic [8:0] expVal();
    return {(mSt != 0), 1'b0, mT6, mTo, 2'b00, mT2, 2'b00};
  endfunction

  // One cycle: inputs already driven at negedge; clock, update model, compare
  task automatic cyc(input string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(tag, {statusMode, statusByte}, expVal());
    oeRead = 0; ceRead = 0; startProg = 0; startErase = 0;
    suspendCmd = 0; resumeCmd = 0; resetCmd = 0; opDone = 0;
    pulseTick = 0; progFault = 0;
  endtask

  task automatic rd(input int a, input bit viaCe, input string tag);
    secAddr = 3'(a);
    if (viaCe) ceRead = 1; else oeRead = 1;
    cyc(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin pulseTick = 1; cyc(tag); end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset state", {statusMode, statusByte}, 9'h000);
    rstN = 1;
    cyc("R1 idle after reset");
    rd(3, 0, "R4 idle read holds");

    // Program flow
    startProg = 1; cyc("R2 program start");
    check("R2 mode raised", {8'h00, statusMode}, 9'h001);
    rd(0, 0, "R3 oe read program");
    check("R3 bit6 flipped", {8'h00, statusByte[6]}, 9'h001);
    rd(5, 1, "R3 ce read program");
    rd(2, 0, "R5 no bit2 in program");
    startErase = 1; eraseMask = 8'hFF; cyc("R2 start ignored busy");
    ticks(2, "R7 ticks below limit");
    opDone = 1; cyc("R10 program done");
    check("R10 mode low", {8'h00, statusMode}, 9'h000);
    rd(1, 1, "R4 idle read after done");

    // Erase flow
    eraseMask = 8'b0010_0101; startErase = 1; cyc("R2 erase start");
    rd(0, 0, "R5 selected sector");
    rd(1, 0, "R5 unselected sector");
    rd(2, 1, "R5 selected sector ce");
    rd(7, 0, "R5 unselected high sector");
    ticks(2, "R7 erase ticks");
    suspendCmd = 1; cyc("R6 suspend");
    rd(5, 0, "R5 selected while suspended");
    rd(4, 1, "R4 bit6 holds suspended");
    ticks(3, "R6 ticks ignored suspended");
    opDone = 1; cyc("R6 done ignored suspended");
    resumeCmd = 1; cyc("R6 resume");
    ticks(3, "R7 approach limit");
    check("R7 bit5 not yet", {8'h00, statusByte[5]}, 9'h000);
    ticks(1, "R7 limit reached");
    check("R7 bit5 set", {8'h00, statusByte[5]}, 9'h001);
    opDone = 1; cyc("R9 done ignored timed out");
    rd(0, 0, "R9 still toggling");
    ticks(2, "R9 sticky");
    suspendCmd = 1; cyc("R6 suspend after timeout");
    resumeCmd = 1; cyc("R6 resume after timeout");
    resetCmd = 1; startProg = 1; cyc("R11 reset clears");
    check("R11 all zero", {statusMode, statusByte}, 9'h000);

    // Both starts together, then overwrite fault
    startProg = 1; startErase = 1; eraseMask = 8'hFF; cyc("R2 program wins");
    rd(3, 0, "R2 bit2 silent program");
    suspendCmd = 1; cyc("R6 suspend ignored in program");
    progFault = 1; cyc("R8 fault sets bit5");
    opDone = 1; cyc("R9 done ignored after fault");
    resetCmd = 1; rd(3, 1, "R11 reset beats read");

    // Clean erase completion
    eraseMask = 8'b1000_0000; startErase = 1; cyc("R2 erase start again");
    rd(7, 1, "R5 top sector selected");
    opDone = 1; rd(7, 0, "R10 erase done with read");
    rd(7, 0, "R4 R12 idle hold");
    finish();
  end

endmodule